// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside the register file of a 16550-style serial port. It takes five raw interrupt conditions and their enable bits, and picks the single most urgent pending condition. The five conditions are a receive-line error, receive data available, a receive character timeout, transmit holding empty, and a modem status change. The result is an 8-bit read-only identification value. The block also drives a single interrupt request line. The condition flags and their clear pulses belong to neighbouring logic, so this unit only observes the flag levels.

While the host reads the identification value, a small two-state machine freezes the reported byte so that the read sees one consistent value. In state ST_LIVE the output follows the live priority code. On the first cycle that the read strobe is high, the live code is captured and the machine takes transition T_CAPTURE to ST_HOLD. ST_HOLD reports the captured byte for as long as the strobe stays high, and also for the first cycle in which the strobe is low. From that low cycle, transition T_RELEASE returns the machine to ST_LIVE. In every other case the machine stays where it is (T_STAY_LIVE, T_STAY_HOLD).

Top module: `uart_intid`

## Requirements
- R1: Among enabled pending conditions, the reported one follows this ranking, highest first: line error, then receive data, then receive timeout, then transmit empty, then modem change. Receive data outranks timeout even though the two share one level.
- R2: Bit 0 is active low. With no enabled condition pending, bits 3:0 read 0001.
- R3: Bits 3:0 read 0110 for line error, 0100 for receive data, 0010 for transmit empty and 0000 for modem change. A timeout reads 1100 in FIFO mode. Outside FIFO mode the timeout is ignored, so bit 3 is never set there.
- R4: Bits 5:4 always read 0.
- R5: Bits 7:6 both read 1 when `fifo_on_i` is 1, and both read 0 otherwise.
- R6: A condition takes part only when its enable is set. Receive data and timeout share `en_rx_i`. `irq_o` is 1 whenever any enabled, participating condition is pending now, and this holds even during a read.
- R7: On the first cycle that `id_rd_i` is high, `id_o` shows the live code, and that code is captured. `id_o` then keeps the captured byte while the strobe stays high, and for the first cycle in which the strobe is low.
- R8: After reset the machine is in ST_LIVE. With all inputs low, `id_o` reads 0x01 and `irq_o` reads 0.
- R9: Conditions that change during a read show up on `id_o` in the second cycle after the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_err_i | input | 1 | Receive-line error condition (overrun, parity, framing or break) |
| rx_avail_i | input | 1 | Receive data available condition |
| rx_tmo_i | input | 1 | Receive character timeout condition |
| tx_empty_i | input | 1 | Transmit holding empty condition |
| modem_chg_i | input | 1 | Modem status change condition |
| en_line_i | input | 1 | Enable for the line error condition |
| en_rx_i | input | 1 | Enable for receive data and timeout |
| en_tx_i | input | 1 | Enable for transmit empty |
| en_modem_i | input | 1 | Enable for modem change |
| fifo_on_i | input | 1 | FIFO mode enable |
| id_rd_i | input | 1 | Host read strobe for the identification byte |
| id_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default 8-bit identification width. This is the only width at which the field layout is defined, and it keeps the whole input space small. With the strobe idle, all 1024 combinations of the five flags, the four enables and the FIFO bit are swept. The expected byte and request line for each combination are computed arithmetically, which covers every priority pairing and both FIFO modes. Directed read sequences then change flags and the FIFO bit during a read, and check the exact cycle in which the frozen byte gives way to the live one.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;

    localparam int NIB_W    = 4;
    localparam int MIRROR_W = 2;

    typedef enum logic [0:0] {
        ST_LIVE = 1'b0,
        ST_HOLD = 1'b1
    } hold_st_e;

    localparam logic [NIB_W-1:0] NIB_NONE  = 4'b0001;
    localparam logic [NIB_W-1:0] NIB_LINE  = 4'b0110;
    localparam logic [NIB_W-1:0] NIB_RXD   = 4'b0100;
    localparam logic [NIB_W-1:0] NIB_TMO   = 4'b1100;
    localparam logic [NIB_W-1:0] NIB_THR   = 4'b0010;
    localparam logic [NIB_W-1:0] NIB_MODEM = 4'b0000;

endpackage

// File: rtl/uart_intid_pick.sv
module uart_intid_pick
    import uart_intid_pkg::*;
#(
    parameter int IID_W = 8
) (
    input  logic             line_err_i,
    input  logic             rx_avail_i,
    input  logic             rx_tmo_i,
    input  logic             tx_empty_i,
    input  logic             modem_chg_i,
    input  logic             en_line_i,
    input  logic             en_rx_i,
    input  logic             en_tx_i,
    input  logic             en_modem_i,
    input  logic             fifo_on_i,
    output logic [IID_W-1:0] code_o,
    output logic             any_o
);

    localparam int PAD_W = IID_W - NIB_W - MIRROR_W;

    logic act_line, act_rx, act_tmo, act_tx, act_modem;
    logic [NIB_W-1:0] nib;

    always_comb begin
        act_line  = line_err_i  & en_line_i;
        act_rx    = rx_avail_i  & en_rx_i;
        act_tmo   = rx_tmo_i    & en_rx_i & fifo_on_i;
        act_tx    = tx_empty_i  & en_tx_i;
        act_modem = modem_chg_i & en_modem_i;

        if (act_line)       nib = NIB_LINE;
        else if (act_rx)    nib = NIB_RXD;
        else if (act_tmo)   nib = NIB_TMO;
        else if (act_tx)    nib = NIB_THR;
        else if (act_modem) nib = NIB_MODEM;
        else                nib = NIB_NONE;

        code_o = {{MIRROR_W{fifo_on_i}}, {PAD_W{1'b0}}, nib};
        any_o  = act_line | act_rx | act_tmo | act_tx | act_modem;
    end

endmodule

// File: rtl/uart_intid_hold.sv
module uart_intid_hold
    import uart_intid_pkg::*;
#(
    parameter int IID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic [IID_W-1:0] live_i,
    output logic [IID_W-1:0] code_o
);

    hold_st_e         st_q, st_d;
    logic [IID_W-1:0] frz_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LIVE: if (rd_i)  st_d = ST_HOLD;  // T_CAPTURE
            ST_HOLD: if (!rd_i) st_d = ST_LIVE;  // T_RELEASE
            default: st_d = ST_LIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LIVE;
        else        st_q <= st_d;
    end

    // capture register, loaded on the first strobe cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    frz_q <= '0;
        else if (st_q == ST_LIVE && rd_i) frz_q <= live_i;
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_LIVE: code_o = live_i;
            ST_HOLD: code_o = frz_q;
            default: code_o = live_i;
        endcase
    end

endmodule

// File: rtl/uart_intid.sv
module uart_intid
    import uart_intid_pkg::*;
#(
    parameter int IID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_err_i,
    input  logic             rx_avail_i,
    input  logic             rx_tmo_i,
    input  logic             tx_empty_i,
    input  logic             modem_chg_i,
    input  logic             en_line_i,
    input  logic             en_rx_i,
    input  logic             en_tx_i,
    input  logic             en_modem_i,
    input  logic             fifo_on_i,
    input  logic             id_rd_i,
    output logic [IID_W-1:0] id_o,
    output logic             irq_o
);

    logic [IID_W-1:0] live_code;

    uart_intid_pick #(.IID_W(IID_W)) u_pick (
        .line_err_i  (line_err_i),
        .rx_avail_i  (rx_avail_i),
        .rx_tmo_i    (rx_tmo_i),
        .tx_empty_i  (tx_empty_i),
        .modem_chg_i (modem_chg_i),
        .en_line_i   (en_line_i),
        .en_rx_i     (en_rx_i),
        .en_tx_i     (en_tx_i),
        .en_modem_i  (en_modem_i),
        .fifo_on_i   (fifo_on_i),
        .code_o      (live_code),
        .any_o       (irq_o)
    );

    uart_intid_hold #(.IID_W(IID_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (id_rd_i),
        .live_i (live_code),
        .code_o (id_o)
    );

endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk #(
    parameter int IID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_rd_i,
    input logic [IID_W-1:0] id_o,
    input logic             irq_o,
    input logic             fifo_on_i
);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        id_o[5:4] == 2'b00);

    p_tmo_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        id_o[3] |-> (id_o[2] && id_o[7]));

    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        id_o[3:0] inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && id_rd_i && $past(id_rd_i)) |-> $stable(id_o));

    p_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !id_rd_i && $past(id_rd_i)) |-> $stable(id_o));

    p_irq_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !id_rd_i && !$past(id_rd_i)) |-> (irq_o == !id_o[0]));

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !id_rd_i && !$past(id_rd_i)) |-> (id_o[7:6] == {2{fifo_on_i}}));

endmodule

bind uart_intid uart_intid_chk #(.IID_W(IID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_rd_i   (id_rd_i),
    .id_o      (id_o),
    .irq_o     (irq_o),
    .fifo_on_i (fifo_on_i)
);

// File: tb/uart_intid_test.sv
module uart_intid_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_err_i = 0, rx_avail_i = 0, rx_tmo_i = 0, tx_empty_i = 0, modem_chg_i = 0;
    logic en_line_i = 0, en_rx_i = 0, en_tx_i = 0, en_modem_i = 0, fifo_on_i = 0;
    logic id_rd_i = 0;
    logic [7:0] id_o;
    logic irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_intid uut (
        .clk(clk), .rst_n(rst_n),
        .line_err_i(line_err_i), .rx_avail_i(rx_avail_i), .rx_tmo_i(rx_tmo_i),
        .tx_empty_i(tx_empty_i), .modem_chg_i(modem_chg_i),
        .en_line_i(en_line_i), .en_rx_i(en_rx_i), .en_tx_i(en_tx_i),
        .en_modem_i(en_modem_i), .fifo_on_i(fifo_on_i),
        .id_rd_i(id_rd_i), .id_o(id_o), .irq_o(irq_o)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic clear_all();
        {line_err_i, rx_avail_i, rx_tmo_i, tx_empty_i, modem_chg_i} = '0;
        {en_line_i, en_rx_i, en_tx_i, en_modem_i, fifo_on_i} = '0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        // R8: reset state
        #1;
        chk8("R8 reset id", id_o, 8'h01);
        chk1("R8 reset irq", irq_o, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk8("R8 after reset id", id_o, 8'h01);

        // R1..R6: exhaustive sweep with the strobe idle
        for (int v = 0; v < 1024; v++) begin
            logic [3:0] nib;
            logic [7:0] exp;
            @(negedge clk);
            line_err_i = v[0]; rx_avail_i = v[1]; rx_tmo_i = v[2];
            tx_empty_i = v[3]; modem_chg_i = v[4];
            en_line_i = v[5]; en_rx_i = v[6]; en_tx_i = v[7]; en_modem_i = v[8];
            fifo_on_i = v[9];
            #1;
            nib = 4'd1;
            if (v[4] && v[8]) nib = 4'd0;
            if (v[3] && v[7]) nib = 4'd2;
            if (v[2] && v[6] && v[9]) nib = 4'd12;
            if (v[1] && v[6]) nib = 4'd4;
            if (v[0] && v[5]) nib = 4'd6;
            exp = (v[9] ? 8'd192 : 8'd0) + {4'd0, nib};
            chk8("R1 R2 R3 R4 R5 sweep id", id_o, exp);
            chk1("R6 sweep irq", irq_o, nib != 4'd1);
        end

        // R7 / R9: read with changes during the access
        @(negedge clk);
        clear_all();
        fifo_on_i = 1; en_line_i = 1; en_rx_i = 1; en_tx_i = 1; en_modem_i = 1;
        tx_empty_i = 1;
        #1;
        chk8("R3 live tx empty", id_o, 8'hC2);
        @(negedge clk); id_rd_i = 1; #1;
        chk8("R7 capture cycle", id_o, 8'hC2);
        @(negedge clk); line_err_i = 1; #1;
        chk8("R7 hold after new line error", id_o, 8'hC2);
        chk1("R6 irq live during read", irq_o, 1'b1);
        @(negedge clk); fifo_on_i = 0; #1;
        chk8("R7 hold mirror bits frozen", id_o, 8'hC2);
        @(negedge clk); id_rd_i = 0; #1;
        chk8("R7 tail cycle frozen", id_o, 8'hC2);
        @(negedge clk); #1;
        chk8("R9 released shows new code", id_o, 8'h06);

        // R6 / R9: conditions cleared during a read
        @(negedge clk); id_rd_i = 1; #1;
        chk8("R7 capture line error", id_o, 8'h06);
        @(negedge clk); clear_all(); #1;
        chk8("R7 hold after clear", id_o, 8'h06);
        chk1("R6 irq drops while frozen", irq_o, 1'b0);
        @(negedge clk); id_rd_i = 0; #1;
        chk8("R7 tail after clear", id_o, 8'h06);
        @(negedge clk); #1;
        chk8("R9 released none pending", id_o, 8'h01);

        // R3: timeout in FIFO mode, then outside it
        @(negedge clk); en_rx_i = 1; rx_tmo_i = 1; fifo_on_i = 1; #1;
        chk8("R3 timeout fifo", id_o, 8'hCC);
        @(negedge clk); fifo_on_i = 0; #1;
        chk8("R3 timeout ignored non-fifo", id_o, 8'h01);
        chk1("R6 timeout no irq non-fifo", irq_o, 1'b0);

        summary();
    end

endmodule